// File: doc/BRIEF.md
# Temperature Window Index Generator

This block turns a signed temperature reading into a pointer for a 72-entry compensation table. Each table slot covers two degrees. Readings beyond either end of the covered span select the first or last slot. A small hysteresis band keeps the pointer steady when the reading wobbles by one degree around a window edge.

The pointer is held in a register. It is recomputed only when a new reading is flagged valid. Each recomputation is announced by a one-cycle update strobe, which downstream logic uses to fetch the selected table entry.

A manual override lets a host write the pointer directly. While the override is on, readings are ignored. After the override ends, the next reading reloads the pointer with no hysteresis applied.

Top module: `tlut_index_gen`

## Requirements
- R1: Under synchronous active-low reset, the index output reads 00h and the update strobe is low. Both values are seen at the first clock edge after reset is released, until a sample arrives.
- R2: The sample is 8-bit two's complement, 1 °C per LSB. The first valid sample after reset loads index = 80h + floor((T + 41) / 2) for T in -39..+100. For example, -39 and -38 give 81h, 25 gives A1h, and 100 gives C6h.
- R3: A reading of -40 or colder maps to slot 80h. A reading of +101 or hotter maps to slot C7h. Once a reading is more than 1 °C below -40, or is +101 or hotter, the index is 80h or C7h respectively, whatever the earlier state.
- R4: When the mapped slot of a valid sample is above the current slot, the index moves to that slot in a single step. A jump over several slots also happens in one step.
- R5: The index moves down only when the reading is more than 1 °C below the lowest temperature of the current window. The lowest temperature of slot 80h+k is 2k-41, for k ≥ 1. When the index moves down, it takes the mapped slot. Otherwise it holds.
- R6: The update strobe is high for exactly the cycle after each valid sample taken in automatic mode. It is low in every other cycle, including all cycles in manual mode.
- R7: Without a valid sample in automatic mode, the index holds its value, whatever the temperature input does.
- R8: While manual override is high, the index takes the host value on each clock and temperature samples have no effect.
- R9: The first valid sample after manual override is released loads the mapped slot directly, with no hysteresis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_i | input | 8 | Signed temperature sample, 1 °C per LSB |
| temp_valid_i | input | 1 | Sample-valid strobe |
| manual_en_i | input | 1 | Manual override enable |
| manual_idx_i | input | 8 | Host-written index used in manual mode |
| idx_o | output | 8 | Registered table address |
| upd_o | output | 1 | One-cycle strobe after each automatic recomputation |

## Verification
The block's internal state is the index register plus a flag recording whether a first sample has been taken. Either one going wrong shows up on the index output one clock after the next valid sample:

- A wrong edge computation shows up as an index that follows a one-degree wobble when it should hold, or one that fails to drop once the reading leaves the hysteresis band.
- A stale first-sample flag shows up after reset or after manual release, as an index that applies hysteresis when it should load the mapped slot directly.

The bench runs a behavioural model alongside the design and compares both outputs every cycle. Because of this, a divergence is reported in the cycle where it first appears.

// File: rtl/tlut_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the temperature window index generator.
// Holds the decision encoding passed from the hysteresis stage to the register.
package tlut_pkg;

    // What the next valid sample does to the held index.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,   // keep the current slot
        ACT_LOAD = 2'd1,   // first sample: take the mapped slot directly
        ACT_UP   = 2'd2,   // mapped slot is higher: move up
        ACT_DOWN = 2'd3    // reading left the band below: move down
    } tlut_act_e;

endpackage

// File: rtl/tlut_nominal.sv
`timescale 1ns/1ps
// Maps a signed temperature sample to its nominal table slot (0..SLOTS-1).
// Slot k >= 1 covers [LOW_T + 2k - 1, LOW_T + 2k]. Slot 0 takes everything
// at or below LOW_T, and the last slot takes everything at or above its
// lower edge.
// Assumes the sample is two's complement with 1 degree per LSB.
module tlut_nominal #(
    parameter int TEMP_W = 8,
    parameter int SLOTS  = 72,
    parameter int LOW_T  = -40
) (
    input  logic [TEMP_W-1:0]         temp_i,
    output logic [$clog2(SLOTS)-1:0]  nom_slot_o
);
    localparam int SW = $clog2(SLOTS);
    localparam int CW = TEMP_W + 4;
    localparam logic signed [CW-1:0] LO_C  = CW'(LOW_T);
    localparam logic signed [CW-1:0] TOP_C = CW'(LOW_T + 2 * (SLOTS - 1) - 1);

    logic signed [CW-1:0] t_ext;
    logic signed [CW-1:0] offset;

    // Sign-extend the sample and shift it so that slot 1 starts at offset 2.
    always_comb begin
        t_ext  = CW'($signed(temp_i));
        offset = t_ext - LO_C + CW'(1);
    end

    // Saturate at both ends; inside the range, take the two-degree window number.
    always_comb begin
        if (t_ext <= LO_C) begin
            nom_slot_o = '0;
        end else if (t_ext >= TOP_C) begin
            nom_slot_o = SW'(SLOTS - 1);
        end else begin
            nom_slot_o = SW'(offset >>> 1);
        end
    end

endmodule

// File: rtl/tlut_hyst.sv
`timescale 1ns/1ps
// Chooses what the next valid sample does to the held slot.
// The slot moves up as soon as the mapped slot is higher. It moves down only
// when the reading is more than HYST degrees below the current window's
// lowest temperature.
// Assumes cur_slot_i is in range whenever primed_i is high.
module tlut_hyst
    import tlut_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int SLOTS  = 72,
    parameter int LOW_T  = -40,
    parameter int HYST   = 1
) (
    input  logic                      primed_i,
    input  logic [$clog2(SLOTS)-1:0]  cur_slot_i,
    input  logic [$clog2(SLOTS)-1:0]  nom_slot_i,
    input  logic [TEMP_W-1:0]         temp_i,
    output tlut_act_e                 act_o
);
    localparam int SW = $clog2(SLOTS);
    localparam int CW = TEMP_W + 4;
    localparam logic signed [CW-1:0] LO_C = CW'(LOW_T);

    logic signed [CW-1:0] t_ext;
    logic signed [CW-1:0] low_edge;
    logic signed [CW-1:0] down_lim;

    // Lowest temperature of the current window, and the threshold below it.
    always_comb begin
        t_ext    = CW'($signed(temp_i));
        low_edge = LO_C + $signed(CW'({cur_slot_i, 1'b0})) - CW'(1);
        down_lim = low_edge - CW'(HYST);
    end

    // Priority: first load, then an upward move, then a downward move.
    always_comb begin
        if (!primed_i) begin
            act_o = ACT_LOAD;
        end else if (nom_slot_i > cur_slot_i) begin
            act_o = ACT_UP;
        end else if ((cur_slot_i != SW'(0)) && (t_ext < down_lim)) begin
            act_o = ACT_DOWN;
        end else begin
            act_o = ACT_HOLD;
        end
    end

endmodule

// File: rtl/tlut_index_gen.sv
`timescale 1ns/1ps
// Temperature window index generator.
// Holds the table address, recomputes it on each valid sample in automatic
// mode, and follows a host value in manual mode.
// Assumes samples are two's complement with 1 degree per LSB, and that
// BASE + SLOTS fits in IDX_W bits.
module tlut_index_gen
    import tlut_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int IDX_W  = 8,
    parameter int SLOTS  = 72,
    parameter int BASE   = 128,
    parameter int LOW_T  = -40,
    parameter int HYST   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_valid_i,
    input  logic              manual_en_i,
    input  logic [IDX_W-1:0]  manual_idx_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              upd_o
);
    localparam int SW = $clog2(SLOTS);

    logic [IDX_W-1:0] idx_q;
    logic             upd_q;
    logic             primed_q;
    logic [SW-1:0]    cur_slot;
    logic [SW-1:0]    nom_slot;
    tlut_act_e        act;

    // Current slot number, relative to the table base.
    always_comb begin
        cur_slot = SW'(idx_q - IDX_W'(BASE));
    end

    tlut_nominal #(
        .TEMP_W (TEMP_W),
        .SLOTS  (SLOTS),
        .LOW_T  (LOW_T)
    ) u_nominal (
        .temp_i     (temp_i),
        .nom_slot_o (nom_slot)
    );

    tlut_hyst #(
        .TEMP_W (TEMP_W),
        .SLOTS  (SLOTS),
        .LOW_T  (LOW_T),
        .HYST   (HYST)
    ) u_hyst (
        .primed_i   (primed_q),
        .cur_slot_i (cur_slot),
        .nom_slot_i (nom_slot),
        .temp_i     (temp_i),
        .act_o      (act)
    );

    // Index register, first-sample flag and update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            upd_q    <= 1'b0;
            primed_q <= 1'b0;
        end else if (manual_en_i) begin
            idx_q    <= manual_idx_i;
            upd_q    <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            upd_q <= temp_valid_i;
            if (temp_valid_i) begin
                primed_q <= 1'b1;
                if (act != ACT_HOLD) begin
                    idx_q <= IDX_W'(BASE) + IDX_W'(nom_slot);
                end
            end
        end
    end

    assign idx_o = idx_q;
    assign upd_o = upd_q;

endmodule

// File: rtl/tlut_index_gen_chk.sv
`timescale 1ns/1ps
// Property checker for the temperature window index generator.
// Observes the ports only; attached to every instance of the top module by bind.
module tlut_index_gen_chk #(
    parameter int TEMP_W = 8,
    parameter int IDX_W  = 8,
    parameter int SLOTS  = 72,
    parameter int BASE   = 128,
    parameter int LOW_T  = -40,
    parameter int HYST   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_valid_i,
    input  logic              manual_en_i,
    input  logic [IDX_W-1:0]  manual_idx_i,
    input  logic [IDX_W-1:0]  idx_o,
    input  logic              upd_o
);
    localparam int COLD_LIM = LOW_T - HYST;
    localparam int HOT_LIM  = LOW_T + 2 * (SLOTS - 1) - 1;
    localparam logic [IDX_W-1:0] IDX_LO = IDX_W'(BASE);
    localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(BASE + SLOTS - 1);

    logic auto_smp;
    logic cold_smp;
    logic hot_smp;

    // Classify the sample presented this cycle.
    always_comb begin
        auto_smp = temp_valid_i && !manual_en_i;
        cold_smp = auto_smp && ($signed(temp_i) < COLD_LIM);
        hot_smp  = auto_smp && ($signed(temp_i) >= HOT_LIM);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (idx_o == '0) && !upd_o);                     // R1
    AST_UPD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (idx_o >= IDX_LO) && (idx_o <= IDX_HI));              // R2
    AST_COLD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        cold_smp |=> idx_o == IDX_LO);                                  // R3
    AST_HOT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        hot_smp |=> idx_o == IDX_HI);                                   // R3
    AST_UPD_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        auto_smp |=> upd_o);                                            // R6
    AST_UPD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_smp |=> !upd_o);                                          // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!temp_valid_i && !manual_en_i) |=> $stable(idx_o));            // R7
    AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        manual_en_i |=> idx_o == $past(manual_idx_i));                  // R8

endmodule

bind tlut_index_gen tlut_index_gen_chk #(
    .TEMP_W (TEMP_W),
    .IDX_W  (IDX_W),
    .SLOTS  (SLOTS),
    .BASE   (BASE),
    .LOW_T  (LOW_T),
    .HYST   (HYST)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .temp_i       (temp_i),
    .temp_valid_i (temp_valid_i),
    .manual_en_i  (manual_en_i),
    .manual_idx_i (manual_idx_i),
    .idx_o        (idx_o),
    .upd_o        (upd_o)
);

// File: tb/test_tlut_index_gen.sv
`timescale 1ns/1ps
// Bench for tlut_index_gen: directed corner cases plus a random walk,
// with a behavioural reference model compared on every clock.
module test_tlut_index_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] temp = 8'd0;
    logic       tv = 1'b0;
    logic       men = 1'b0;
    logic [7:0] midx = 8'd0;
    logic [7:0] idx;
    logic       upd;

    int    n_chk = 0;
    int    n_bad = 0;
    string phase = "R1";
    bit    finished = 1'b0;

    // Reference model state.
    int m_idx = 0;
    bit m_upd = 1'b0;
    bit m_primed = 1'b0;
    int m_t;
    int m_n;
    int m_c;

    always #10 clk = ~clk;

    tlut_index_gen i_tlut_index_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_i       (temp),
        .temp_valid_i (tv),
        .manual_en_i  (men),
        .manual_idx_i (midx),
        .idx_o        (idx),
        .upd_o        (upd)
    );

    // Mapped slot number for a temperature, per R2 and R3.
    function automatic int nom_slot(int t);
        if (t <= -40) return 0;
        if (t >= 101) return 71;
        return (t + 41) / 2;
    endfunction

    // Reference model, evaluated on each rising edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_upd = 1'b0; m_primed = 1'b0;
        end else if (men) begin
            m_idx = midx; m_upd = 1'b0; m_primed = 1'b0;
        end else begin
            m_upd = tv;
            if (tv) begin
                m_t = $signed(temp);
                m_n = nom_slot(m_t);
                m_c = m_idx - 128;
                if (!m_primed) m_idx = 128 + m_n;
                else if (m_n > m_c) m_idx = 128 + m_n;
                else if (m_c > 0 && m_t < 2 * m_c - 42) m_idx = 128 + m_n;
                m_primed = 1'b1;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait for the falling edge, then compare both outputs with the model.
    task automatic cyc();
        @(negedge clk);
        chk(phase, int'(idx), m_idx);
        chk(phase, int'(upd), int'(m_upd));
    endtask

    task automatic drive(int t, bit v, bit m, int mi);
        temp = 8'(t); tv = v; men = m; midx = 8'(mi);
        cyc();
    endtask

    // One valid sample, followed by a check against a hand-computed index.
    task automatic smp(string req, int t, int exp);
        phase = req;
        drive(t, 1'b1, 1'b0, 0);
        chk(req, int'(idx), exp);
        chk(req, int'(upd), 1);
        tv = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tv = 1'b0; men = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        cyc();
        chk("R1", int'(idx), 0);
        chk("R1", int'(upd), 0);
    endtask

    initial begin
        int t_walk;
        @(negedge clk);
        do_reset();

        smp("R2", 25, 'hA1);
        smp("R4", 27, 'hA2);
        smp("R5", 26, 'hA2);   // one degree below the window edge: hold
        smp("R5", 25, 'hA1);   // beyond the band: move down
        smp("R5", 26, 'hA1);
        smp("R4", 27, 'hA2);
        smp("R4", 40, 'hA8);   // multi-slot jump
        smp("R3", -50, 'h80);
        smp("R3", -40, 'h80);
        smp("R3", 120, 'hC7);
        smp("R5", 100, 'hC7);
        smp("R5", 99, 'hC6);

        phase = "R7";
        for (int i = 0; i < 4; i++) begin
            drive(-100 + i, 1'b0, 1'b0, 0);
            chk("R7", int'(idx), 'hC6);
            chk("R6", int'(upd), 0);
        end

        phase = "R8";
        drive(0, 1'b1, 1'b1, 'h55);
        chk("R8", int'(idx), 'h55);
        chk("R8", int'(upd), 0);
        drive(-100, 1'b1, 1'b1, 'h55);
        chk("R8", int'(idx), 'h55);
        drive(0, 1'b0, 1'b1, 'h3C);
        chk("R8", int'(idx), 'h3C);
        men = 1'b0;

        smp("R9", 0, 'h94);

        do_reset(); smp("R3", -128, 'h80);
        do_reset(); smp("R3", 127, 'hC7);
        do_reset(); smp("R2", -39, 'h81);
        do_reset(); smp("R2", -38, 'h81);
        do_reset(); smp("R2", 100, 'hC6);
        do_reset(); smp("R3", 101, 'hC7);
        do_reset(); smp("R3", -40, 'h80);

        // Random walk near window edges, with occasional manual override.
        phase = "R6";
        t_walk = 20;
        for (int i = 0; i < 3000; i++) begin
            t_walk = t_walk + int'($urandom_range(0, 4)) - 2;
            if (i % 500 == 250) t_walk = int'($urandom_range(0, 255)) - 128;
            if (t_walk > 127) t_walk = 127;
            if (t_walk < -128) t_walk = -128;
            drive(t_walk, ($urandom_range(0, 1) == 1),
                  ($urandom_range(0, 15) == 0), int'($urandom_range(0, 255)));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s watchdog actual=running expected=done", phase);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule